// File: doc/BRIEF.md
# Dual-Bank Nonvolatile Array Command Sequencer

This block controls an on-chip nonvolatile array split into two banks that run independently. Each bank has its own small register set on a shared register bus: a read-only status word, a mode word that selects the access width, an 8-bit command register, a 16-bit data register and a 16-bit halfword address register. Software loads the address and data, then writes a command code. The codes read a halfword into the data register, program a halfword, or erase the page that holds the address.

Program and erase run against a per-bank busy timer. The erase time is a fixed cycle count. The program time comes from a table indexed by the 3-bit clock-divider input. Timings are parameters in clock cycles, so a simulation can scale them down. Programming ANDs the new data into the stored halfword, so bits can only be cleared. An erase restores a whole 256-halfword page to all ones. The sequencer counts how often each halfword has been programmed since its page was last erased. It refuses a third program to the same halfword and raises a fault instead.

Top module: `flash_dual_seq`

## Requirements
- R1: After reset, every status word reads 0, every mode word reads 0x0001, and every array halfword reads 0xFFFF.
- R2: Command code 0x02 with mode bits [1:0] = 01 (halfword) programs the halfword at the address register. When the operation ends, the location holds its old value AND the data register, and the done bit is set.
- R3: A program holds the bank busy for exactly U×k cycles, where U is the PROG_UNIT parameter (default 2). k is 10 for divider 0–3, 14 for divider 4–5, 16 for divider 6 and 21 for divider 7, which are the 50/70/80/105 µs times in 5 µs steps.
- R4: Command code 0x03 erases the 256-halfword page that holds the address (address bits above bit 7 pick the page). It holds the bank busy for exactly ERASE_CYC cycles whatever the divider. Afterwards every halfword of that page reads 0xFFFF, and other pages are unchanged.
- R5: A third program to a halfword since its page was last erased is refused. The fault bit is set, the bank never becomes busy, and the stored value is unchanged. A page erase restores two programs to each halfword of the page.
- R6: A program command while the mode width bits are not 01 (00 byte, 10 word, 11) is rejected. The command-error bit is set, the bank stays idle, and the array is unchanged.
- R7: Any command write while the bank is busy is ignored and sets the command-error bit. The running operation finishes at its original time with its original result.
- R8: The banks are independent. One bank can read and program while the other is erasing.
- R9: Status bits are: bit 0 busy, bit 1 done, bit 2 fault, bit 3 command error. Bits 1 to 3 clear when the status word is read. A new event in the same cycle wins over the clear.
- R10: Command code 0x01 copies the addressed halfword into the data register on the next clock. Any command code other than 0x01, 0x02 or 0x03 sets the command-error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cd | input | 3 | Clock-divider setting that selects the program time |
| bus_bank | input | 1 | Bank select for the register access |
| bus_reg | input | 3 | Register index: 0 status, 1 mode, 2 command, 3 data, 4 address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status flags when it reads status) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| bank_busy | output | 2 | Busy flag of each bank |

## Verification
The hardest state to reach is a bank that is in the middle of a long erase while commands arrive for it and the other bank runs a full program and read cycle. The bench starts an erase with the divider at its slowest setting. It writes a command to the erasing bank, then programs and reads back the other bank while it polls the busy outputs. Last, it times the erase against its nominal length. The third-program refusal needs a halfword driven through two accepted programs first. The bench does this and then proves, with a fresh program, that the erase restored the allowance.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int unsigned HW_PER_PAGE = 256;

  localparam logic [2:0] REG_STAT = 3'd0;
  localparam logic [2:0] REG_MODE = 3'd1;
  localparam logic [2:0] REG_CMD  = 3'd2;
  localparam logic [2:0] REG_DATA = 3'd3;
  localparam logic [2:0] REG_ADDR = 3'd4;

  localparam logic [7:0] CMD_READ  = 8'h01;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_ERASE = 8'h03;

  localparam logic [1:0] WID_HALF = 2'b01;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_e;

  // program time in 5 us steps, indexed by divider
  function automatic int unsigned prog_units(input logic [2:0] div);
    int unsigned u;
    case (div)
      3'd4, 3'd5: u = 14;
      3'd6:       u = 16;
      3'd7:       u = 21;
      default:    u = 10;
    endcase
    return u;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          running,
  output logic          expire
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val - CW'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end

  assign running = run_q;
  assign expire  = run_q && (cnt_q == '0);

  AST_TMR_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !run_q); // R7
  AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0)); // R3
endmodule

// File: rtl/flash_bank.sv
module flash_bank
  import flash_seq_pkg::*;
#(
  parameter int unsigned PAGES     = 2,
  parameter int unsigned PROG_UNIT = 2,
  parameter int unsigned ERASE_CYC = 300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cd,
  input  logic        wr,
  input  logic        rd,
  input  logic [2:0]  reg_sel,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        busy
);
  localparam int unsigned DEPTH = PAGES * HW_PER_PAGE;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned MAXC  = max_u(ERASE_CYC, 21 * PROG_UNIT);
  localparam int unsigned CW    = $clog2(MAXC + 1);

  logic [15:0] mem  [DEPTH];
  logic [1:0]  wcnt [DEPTH];

  logic [15:0] mode_q, data_q, addr_q;
  logic [7:0]  cmd_q;
  logic        done_q, fault_q, cerr_q;
  op_e         op_kind;
  logic [AW-1:0] op_idx;
  logic [15:0] op_data;

  logic [AW-1:0] a_idx;
  logic [1:0]    cnt_at_a;
  logic          cmd_wr, idle, is_prog, known;
  logic          start_prog, start_erase, read_ev, over_prog_ev, cmd_err_ev, finish_ev;
  logic          stat_rd, tmr_run;
  logic [CW-1:0] tmr_val;

  assign a_idx    = addr_q[AW-1:0];
  assign cnt_at_a = wcnt[a_idx];
  assign cmd_wr   = wr && (reg_sel == REG_CMD);
  assign idle     = !tmr_run;
  assign is_prog  = (wdata[7:0] == CMD_PROG);
  assign known    = (wdata[7:0] == CMD_READ) || is_prog || (wdata[7:0] == CMD_ERASE);

  assign start_prog   = cmd_wr && idle && is_prog && (mode_q[1:0] == WID_HALF) && (cnt_at_a != 2'd2);
  assign over_prog_ev = cmd_wr && idle && is_prog && (mode_q[1:0] == WID_HALF) && (cnt_at_a == 2'd2);
  assign start_erase  = cmd_wr && idle && (wdata[7:0] == CMD_ERASE);
  assign read_ev      = cmd_wr && idle && (wdata[7:0] == CMD_READ);
  assign cmd_err_ev   = cmd_wr && (!idle || !known || (is_prog && mode_q[1:0] != WID_HALF));
  assign stat_rd      = rd && (reg_sel == REG_STAT);

  assign tmr_val = start_erase ? CW'(ERASE_CYC) : CW'(prog_units(cd) * PROG_UNIT);

  flash_op_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_prog || start_erase),
    .load_val (tmr_val),
    .running  (tmr_run),
    .expire   (finish_ev)
  );

  assign busy = tmr_run;

  // storage array with per-halfword program counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i]  <= 16'hFFFF;
        wcnt[i] <= 2'd0;
      end
    end else if (finish_ev) begin
      if (op_kind == OP_PROG) begin
        mem[op_idx]  <= mem[op_idx] & op_data;
        wcnt[op_idx] <= wcnt[op_idx] + 2'd1;
      end else if (op_kind == OP_ERASE) begin
        for (int i = 0; i < HW_PER_PAGE; i++) begin
          mem[{op_idx[AW-1:8], 8'(i)}]  <= 16'hFFFF;
          wcnt[{op_idx[AW-1:8], 8'(i)}] <= 2'd0;
        end
      end
    end
  end

  // operation latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_kind <= OP_NONE;
      op_idx  <= '0;
      op_data <= '0;
    end else if (start_prog || start_erase) begin
      op_kind <= start_prog ? OP_PROG : OP_ERASE;
      op_idx  <= a_idx;
      op_data <= data_q;
    end
  end

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 16'h0001;
      data_q <= '0;
      addr_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (wr && reg_sel == REG_MODE) mode_q <= wdata;
      if (wr && reg_sel == REG_ADDR) addr_q <= wdata;
      if (read_ev)                   data_q <= mem[a_idx];
      else if (wr && reg_sel == REG_DATA) data_q <= wdata;
      if (start_prog || start_erase || read_ev) cmd_q <= wdata[7:0];
    end
  end

  // sticky status flags, event wins over clear-on-read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      cerr_q  <= 1'b0;
    end else begin
      if (finish_ev)         done_q <= 1'b1;
      else if (stat_rd)      done_q <= 1'b0;
      if (over_prog_ev)      fault_q <= 1'b1;
      else if (stat_rd)      fault_q <= 1'b0;
      if (cmd_err_ev)        cerr_q <= 1'b1;
      else if (stat_rd)      cerr_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      REG_STAT: rdata = {12'd0, cerr_q, fault_q, done_q, tmr_run};
      REG_MODE: rdata = mode_q;
      REG_CMD:  rdata = {8'd0, cmd_q};
      REG_DATA: rdata = data_q;
      REG_ADDR: rdata = addr_q;
      default:  rdata = '0;
    endcase
  end

  AST_BUSY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_prog || start_erase)); // R2
  AST_DONE_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q); // R9
  AST_OVERPROG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    over_prog_ev |=> (!busy && fault_q)); // R5
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> (cerr_q && $stable(op_kind) && $stable(op_idx))); // R7
  AST_WIDTH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && idle && is_prog && mode_q[1:0] != WID_HALF) |=> (!busy && cerr_q)); // R6
  AST_WCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_at_a != 2'd3); // R5
endmodule

// File: rtl/flash_dual_seq.sv
module flash_dual_seq #(
  parameter int unsigned PAGES     = 2,
  parameter int unsigned PROG_UNIT = 2,
  parameter int unsigned ERASE_CYC = 300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cd,
  input  logic        bus_bank,
  input  logic [2:0]  bus_reg,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic [1:0]  bank_busy
);
  localparam int unsigned NBANK = 2;

  logic [15:0] rd_bank [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = (bus_bank == 1'(b));
    flash_bank #(
      .PAGES     (PAGES),
      .PROG_UNIT (PROG_UNIT),
      .ERASE_CYC (ERASE_CYC)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cd      (cd),
      .wr      (bus_wr && sel),
      .rd      (bus_rd && sel),
      .reg_sel (bus_reg),
      .wdata   (bus_wdata),
      .rdata   (rd_bank[b]),
      .busy    (bank_busy[b])
    );
  end

  assign bus_rdata = rd_bank[bus_bank];

  AST_BANK_WR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_bank && !bank_busy[0]) |=> !$rose(bank_busy[0])); // R8
endmodule

// File: tb/sim_flash_dual_seq.sv
module sim_flash_dual_seq;
  localparam int UNIT  = 2;
  localparam int ERASE = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cd = 3'd0;
  logic        bus_bank = 1'b0;
  logic [2:0]  bus_reg = 3'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [1:0]  bank_busy;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_dual_seq #(.PAGES(2), .PROG_UNIT(UNIT), .ERASE_CYC(ERASE)) u0 (
    .clk(clk), .rst_n(rst_n), .cd(cd), .bus_bank(bus_bank), .bus_reg(bus_reg),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bank_busy(bank_busy)
  );

  function automatic int exp_cycles(input int div);
    int us;
    us = (div < 4) ? 50 : (div < 6) ? 70 : (div == 6) ? 80 : 105;
    return (us / 5) * UNIT;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic b, input logic [2:0] r, input logic [15:0] v);
    @(negedge clk);
    bus_bank = b; bus_reg = r; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic b, input logic [2:0] r, output logic [15:0] v);
    @(negedge clk);
    bus_bank = b; bus_reg = r; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_arr(input logic b, input logic [15:0] a, output logic [15:0] v);
    wr(b, 3'd4, a);
    wr(b, 3'd2, 16'h0001);
    rd(b, 3'd3, v);
  endtask

  task automatic prog(input logic b, input logic [15:0] a, input logic [15:0] d, output int dur);
    int c0;
    wr(b, 3'd3, d);
    wr(b, 3'd4, a);
    wr(b, 3'd2, 16'h0002);
    c0 = cyc;
    while (bank_busy[b]) @(negedge clk);
    dur = cyc - c0;
  endtask

  task automatic run_all;
    logic [15:0] v;
    int dur, c0, bad;
    // R1 reset state
    rd(1'b0, 3'd0, v); check("R1 status bank0", v, 0);
    rd(1'b1, 3'd0, v); check("R1 status bank1", v, 0);
    rd(1'b0, 3'd1, v); check("R1 mode bank0", v, 16'h0001);
    rd_arr(1'b0, 16'd0, v);   check("R1 array first", v, 16'hFFFF);
    rd_arr(1'b1, 16'd511, v); check("R1 array last", v, 16'hFFFF);

    // R2/R3 divider sweep
    for (int k = 0; k < 8; k++) begin
      cd = 3'(k);
      prog(1'b0, 16'(16 + k), 16'hFFFF ^ (16'h1 << k), dur);
      check("R3 program duration", dur, exp_cycles(k));
      rd(1'b0, 3'd0, v); check("R9 done after program", v, 16'h0002);
      rd(1'b0, 3'd0, v); check("R9 done cleared by read", v, 0);
      rd_arr(1'b0, 16'(16 + k), v); check("R2 programmed value", v, 16'hFFFF ^ (16'h1 << k));
    end

    // R2 AND merge, R5 third program refused
    cd = 3'd0;
    prog(1'b0, 16'd40, 16'hA5A5, dur); rd(1'b0, 3'd0, v);
    prog(1'b0, 16'd40, 16'h0F0F, dur); rd(1'b0, 3'd0, v);
    rd_arr(1'b0, 16'd40, v); check("R2 AND merge", v, 16'h0505);
    prog(1'b0, 16'd40, 16'h0000, dur);
    check("R5 third program not busy", dur, 0);
    rd(1'b0, 3'd0, v); check("R5 fault bit", v, 16'h0004);
    rd_arr(1'b0, 16'd40, v); check("R5 value unchanged", v, 16'h0505);

    // R6 width rejection
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      wr(1'b0, 3'd1, 16'(m));
      prog(1'b0, 16'd60, 16'h0000, dur);
      check("R6 no busy on bad width", dur, 0);
      rd(1'b0, 3'd0, v); check("R6 cmd error", v, 16'h0008);
    end
    wr(1'b0, 3'd1, 16'h0001);
    rd_arr(1'b0, 16'd60, v); check("R6 array unchanged", v, 16'hFFFF);

    // R10 unknown code
    wr(1'b0, 3'd2, 16'h007E);
    rd(1'b0, 3'd0, v); check("R10 unknown code error", v, 16'h0008);

    // R4/R7/R8 erase with concurrent traffic
    prog(1'b0, 16'd300, 16'h1234, dur); rd(1'b0, 3'd0, v);
    cd = 3'd7;
    wr(1'b0, 3'd4, 16'd40);
    wr(1'b0, 3'd2, 16'h0003);
    c0 = cyc;
    wr(1'b0, 3'd4, 16'd41);
    wr(1'b0, 3'd2, 16'h0002);
    rd(1'b0, 3'd0, v); check("R7 busy plus cmd error", v, 16'h0009);
    prog(1'b1, 16'd5, 16'h00FF, dur);
    check("R8 bank1 program during erase", dur, exp_cycles(7));
    rd_arr(1'b1, 16'd5, v); check("R8 bank1 readback", v, 16'h00FF);
    check("R8 bank0 still busy", int'(bank_busy[0]), 1);
    while (bank_busy[0]) @(negedge clk);
    check("R4 erase duration", cyc - c0, ERASE);
    rd(1'b0, 3'd0, v); check("R9 done after erase", v, 16'h0002);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      rd_arr(1'b0, 16'(i), v);
      if (v != 16'hFFFF) bad++;
    end
    check("R4 page fully erased", bad, 0);
    rd_arr(1'b0, 16'd300, v); check("R4 other page untouched", v, 16'h1234);
    rd_arr(1'b0, 16'd41, v); check("R7 ignored program", v, 16'hFFFF);
    prog(1'b0, 16'd40, 16'h0000, dur);
    check("R5 allowance restored duration", dur, exp_cycles(7));
    rd_arr(1'b0, 16'd40, v); check("R5 allowance restored value", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule